// File: doc/BRIEF.md
# HDLC Frame Transmitter

This block turns a byte stream into a single-channel HDLC bit stream. Frame bytes arrive with a valid/ready handshake and carry two side markers: `in_last` closes the frame normally and `in_abort` cuts it short. One serial bit leaves on `tx_bit` for each cycle in which the transmit clock enable `bit_en` is high. Between frames the line carries either back-to-back flags or idle ones, as `fill_flags` selects. Each frame is opened by a flag and protected by a 16- or 32-bit frame check sequence. Zero bits are inserted so that frame content never looks like a flag, and the frame is closed by a flag.

The control FSM works on byte slots. The state register says what kind of byte is being shifted out: `ST_IDLE` (eight ones), `ST_FLAG` (a fill or gap flag), `ST_DATA` (a payload byte), `ST_CRC` (a check byte), `ST_CLOSE` (the closing flag) or `ST_ABORT` (eight ones that end a frame early). On the last bit of every byte the next byte is chosen.
- From any between-frame state (`ST_IDLE`, `ST_FLAG`, `ST_CLOSE`, `ST_ABORT`), the FSM goes to `ST_DATA`, or to `ST_ABORT` for an abort beat, when a beat is offered, the byte just sent was a flag and the gap count is met. Otherwise it goes to `ST_FLAG` if flags fill the line or a frame is waiting, and to `ST_IDLE` if not.
- `ST_DATA` goes to `ST_DATA` on a further beat, to `ST_CRC` after the last beat, and to `ST_ABORT` on an abort beat or on underrun.
- `ST_CRC` repeats for two or four bytes, then goes to `ST_CLOSE`.

The gap count counts the flags sent since the last closing flag or abort. It saturates at its maximum and is reset to that maximum.

Top module: `hdlc_tx`

## Requirements
- R1: While reset is held and at reset release, `tx_bit` is 1 and `in_ready` is 0. The first eight bits after reset are ones.
- R2: When no frame is offered, the line carries repeated flags 01111110 if `fill_flags` is 1 and steady ones if it is 0. Fill resumes right after a closing flag or an abort.
- R3: Exactly one bit is emitted per cycle with `bit_en` high. Payload bytes go out least significant bit first. `tx_bit` does not change in a cycle without `bit_en`, and gaps in `bit_en` do not alter the bit sequence.
- R4: The bit immediately before a frame's first payload bit ends a flag. After the check sequence comes a closing flag.
- R5: After five consecutive ones taken from payload or check bits, a 0 is inserted. This includes a run that ends the check sequence or precedes an abort. Flag and abort bits are never stuffed.
- R6: With the width latched as 16 bits, the check sequence uses the reflected polynomial 0x8408. With 32 bits it uses 0xEDB88320. The register is preset to all ones, sent complemented and least significant bit first. The width is sampled from `crc32_sel` when a frame starts and held to its end.
- R7: When the next frame is already offered, exactly `min_flags` flags (0 to 15) follow the closing flag before its payload. With 0, the closing flag also opens the next frame.
- R8: A beat with `in_abort` set has its data ignored. It is followed, after any pending stuffed zero, by eight ones, with no check sequence and no closing flag. Fill then resumes.
- R9: If `in_valid` is low when the next payload byte of an unfinished frame is needed, the frame ends as in R8.
- R10: `in_ready` is high only in a `bit_en` cycle in which a byte boundary is reached and a beat can be taken. A beat transfers when `in_valid` and `in_ready` are both high.
- R11: In idle-ones fill mode a frame is still preceded by at least one flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Serial bit slot enable |
| fill_flags | input | 1 | 1: flags between frames, 0: idle ones |
| min_flags | input | CNT_W | Flags required after a closing flag before the next payload |
| crc32_sel | input | 1 | 1: 32-bit check sequence, 0: 16-bit |
| in_valid | input | 1 | Beat offered |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | Beat is the final payload byte |
| in_abort | input | 1 | Beat ends the frame with an abort |
| in_ready | output | 1 | Beat accepted in this cycle when valid |
| tx_bit | output | 1 | Serial line output |

## Verification
Zero insertion and the byte-boundary decision of the FSM can land on the same bit slot. This happens when a byte ends in five ones: the pending stuffed zero must delay both the handshake and the first bit of the following flag, check byte or abort. The bench provokes this with all-ones payload bytes, with payload whose check bytes end in long runs of ones, and with aborts after ones-heavy data. In each case it compares the whole captured line, bit for bit, against a frame image built from the requirements, including where the inserted zero falls.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

    localparam int BYTE_W = 8;
    localparam int FCS_W  = 32;

    localparam logic [BYTE_W-1:0] FLAG_BYTE = 8'h7E;
    localparam logic [BYTE_W-1:0] ONES_BYTE = 8'hFF;

    localparam logic [FCS_W-1:0] POLY16 = 32'h0000_8408;
    localparam logic [FCS_W-1:0] POLY32 = 32'hEDB8_8320;
    localparam logic [FCS_W-1:0] SEED16 = 32'h0000_FFFF;
    localparam logic [FCS_W-1:0] SEED32 = 32'hFFFF_FFFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FLAG,
        ST_DATA,
        ST_CRC,
        ST_CLOSE,
        ST_ABORT
    } tx_state_t;

    // One byte through the reflected check register, LSB first.
    function automatic logic [FCS_W-1:0] fcs_byte(
        input logic [FCS_W-1:0]  acc,
        input logic [BYTE_W-1:0] din,
        input logic              wide
    );
        logic [FCS_W-1:0] c;
        logic             fb;
        c = acc;
        for (int i = 0; i < BYTE_W; i++) begin
            fb = c[0] ^ din[i];
            c  = c >> 1;
            if (fb) c = c ^ (wide ? POLY32 : POLY16);
        end
        return c;
    endfunction

endpackage

// File: rtl/hdlc_tx_crc.sv
module hdlc_tx_crc
    import hdlc_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              feed,
    input  logic              shift,
    input  logic              wide,
    input  logic [BYTE_W-1:0] din,
    output logic [FCS_W-1:0]  fcs_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fcs_q <= SEED32;
        end else if (start) begin
            fcs_q <= fcs_byte(wide ? SEED32 : SEED16, din, wide);
        end else if (feed) begin
            fcs_q <= fcs_byte(fcs_q, din, wide);
        end else if (shift) begin
            fcs_q <= fcs_q >> BYTE_W;
        end
    end

endmodule

// File: rtl/hdlc_tx_stuff.sv
module hdlc_tx_stuff #(
    parameter int RUN_LEN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic raw_bit,
    input  logic body,
    output logic stuff_now,
    output logic tx_bit
);

    localparam int RUN_W = $clog2(RUN_LEN + 1);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(RUN_LEN);

    logic [RUN_W-1:0] ones_q;

    assign stuff_now = (ones_q == RUN_MAX);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ones_q <= '0;
            tx_bit <= 1'b1;
        end else if (bit_en) begin
            if (stuff_now) begin
                tx_bit <= 1'b0;
                ones_q <= '0;
            end else begin
                tx_bit <= raw_bit;
                ones_q <= (body && raw_bit) ? ones_q + 1'b1 : '0;
            end
        end
    end

endmodule

// File: rtl/hdlc_tx.sv
module hdlc_tx
    import hdlc_tx_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              fill_flags,
    input  logic [CNT_W-1:0]  min_flags,
    input  logic              crc32_sel,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_last,
    input  logic              in_abort,
    output logic              in_ready,
    output logic              tx_bit
);

    localparam int IDX_W = $clog2(BYTE_W);
    localparam int FCS_BYTES = FCS_W / BYTE_W;
    localparam int CIDX_W = $clog2(FCS_BYTES + 1);
    localparam logic [IDX_W-1:0]  IDX_LAST = IDX_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0]  CNT_MAX  = '1;
    localparam logic [CIDX_W-1:0] NB_WIDE  = CIDX_W'(FCS_BYTES);
    localparam logic [CIDX_W-1:0] NB_NARROW = CIDX_W'(FCS_BYTES / 2);

    tx_state_t         state_q, state_d;
    logic [BYTE_W-1:0] byte_q, byte_d;
    logic [IDX_W-1:0]  idx_q;
    logic              last_q, last_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_upd;
    logic              wide_q, wide_d;
    logic [CIDX_W-1:0] cidx_q, cidx_d;

    logic              stuff_now, adv, byte_end;
    logic              raw_bit, body, between, gap_ok, want_beat;
    logic              fcs_start, fcs_feed, fcs_shift, fcs_wide;
    logic [FCS_W-1:0]  fcs_q;

    assign adv      = bit_en && !stuff_now;
    assign byte_end = adv && (idx_q == IDX_LAST);
    assign fcs_wide = fcs_start ? crc32_sel : wide_q;

    hdlc_tx_crc u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .start (fcs_start),
        .feed  (fcs_feed),
        .shift (fcs_shift),
        .wide  (fcs_wide),
        .din   (in_data),
        .fcs_q (fcs_q)
    );

    hdlc_tx_stuff #(.RUN_LEN(5)) u_stuff (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .raw_bit   (raw_bit),
        .body      (body),
        .stuff_now (stuff_now),
        .tx_bit    (tx_bit)
    );

    // State register and datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            byte_q  <= ONES_BYTE;
            idx_q   <= '0;
            last_q  <= 1'b0;
            cnt_q   <= CNT_MAX;
            wide_q  <= 1'b0;
            cidx_q  <= '0;
        end else begin
            state_q <= state_d;
            byte_q  <= byte_d;
            last_q  <= last_d;
            cnt_q   <= cnt_d;
            wide_q  <= wide_d;
            cidx_q  <= cidx_d;
            if (adv) idx_q <= idx_q + 1'b1;
        end
    end

    // Gap bookkeeping seen at the end of the current byte.
    always_comb begin
        unique case (state_q)
            ST_FLAG:           cnt_upd = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
            ST_CLOSE, ST_ABORT: cnt_upd = '0;
            default:           cnt_upd = cnt_q;
        endcase
        between = (state_q == ST_IDLE) || (state_q == ST_FLAG) ||
                  (state_q == ST_CLOSE) || (state_q == ST_ABORT);
        gap_ok  = ((state_q == ST_FLAG) || (state_q == ST_CLOSE)) &&
                  (cnt_upd >= min_flags);
        want_beat = between ? gap_ok : ((state_q == ST_DATA) && !last_q);
    end

    // Next-state logic: choose the following byte at each byte boundary.
    always_comb begin
        state_d   = state_q;
        byte_d    = byte_q;
        last_d    = last_q;
        cnt_d     = cnt_q;
        wide_d    = wide_q;
        cidx_d    = cidx_q;
        fcs_start = 1'b0;
        fcs_feed  = 1'b0;
        fcs_shift = 1'b0;
        if (byte_end) begin
            unique case (state_q)
                ST_IDLE, ST_FLAG, ST_CLOSE, ST_ABORT: begin
                    cnt_d = cnt_upd;
                    if (gap_ok && in_valid) begin
                        wide_d = crc32_sel;
                        if (in_abort) begin
                            state_d = ST_ABORT;
                            byte_d  = ONES_BYTE;
                        end else begin
                            state_d   = ST_DATA;
                            byte_d    = in_data;
                            last_d    = in_last;
                            fcs_start = 1'b1;
                        end
                    end else if (fill_flags || in_valid) begin
                        state_d = ST_FLAG;
                        byte_d  = FLAG_BYTE;
                    end else begin
                        state_d = ST_IDLE;
                        byte_d  = ONES_BYTE;
                    end
                end
                ST_DATA: begin
                    if (last_q) begin
                        state_d   = ST_CRC;
                        byte_d    = ~fcs_q[BYTE_W-1:0];
                        cidx_d    = CIDX_W'(1);
                        fcs_shift = 1'b1;
                    end else if (in_valid && !in_abort) begin
                        byte_d   = in_data;
                        last_d   = in_last;
                        fcs_feed = 1'b1;
                    end else begin
                        state_d = ST_ABORT;
                        byte_d  = ONES_BYTE;
                    end
                end
                ST_CRC: begin
                    if (cidx_q == (wide_q ? NB_WIDE : NB_NARROW)) begin
                        state_d = ST_CLOSE;
                        byte_d  = FLAG_BYTE;
                    end else begin
                        byte_d    = ~fcs_q[BYTE_W-1:0];
                        cidx_d    = cidx_q + 1'b1;
                        fcs_shift = 1'b1;
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    byte_d  = ONES_BYTE;
                end
            endcase
        end
    end

    // Outputs of the FSM.
    always_comb begin
        raw_bit  = byte_q[idx_q];
        body     = (state_q == ST_DATA) || (state_q == ST_CRC);
        in_ready = byte_end && want_beat;
    end

endmodule

// File: rtl/hdlc_tx_chk.sv
module hdlc_tx_chk
    import hdlc_tx_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      bit_en,
    input logic      in_ready,
    input logic      tx_bit,
    input logic      stuff_now,
    input tx_state_t state
);

    logic [BYTE_W-1:0] hist_q;

    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '0;
        else if (bit_en) hist_q <= {tx_bit, hist_q[BYTE_W-1:1]};
    end

    a_r10_ready_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> bit_en);

    a_r3_hold_without_slot: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(tx_bit));

    a_r2_idle_is_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && state == ST_IDLE && !stuff_now) |=> tx_bit);

    a_r8_abort_is_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && state == ST_ABORT && !stuff_now) |=> tx_bit);

    a_r4_flag_before_payload: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_DATA) |-> ({tx_bit, hist_q[BYTE_W-1:1]} == FLAG_BYTE));

endmodule

bind hdlc_tx hdlc_tx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .in_ready  (in_ready),
    .tx_bit    (tx_bit),
    .stuff_now (stuff_now),
    .state     (state_q)
);

// File: tb/hdlc_tx_tb.sv
module hdlc_tx_tb;

    localparam int CLK_PERIOD = 10;
    localparam int CAP_N      = 4096;
    localparam int EXP_N      = 1024;
    localparam int WATCHDOG   = 150000;
    localparam int NVEC       = 6;

    // [31:24] seed, [23:20] len A, [19:16] len B, [15:12] min flags,
    // [11:8] 32-bit check, [7:4] flag fill
    localparam logic [31:0] VECS [NVEC] = '{
        32'hFF130110, 32'h3C423010, 32'hA565F100,
        32'h7E221000, 32'h00812110, 32'hF8340000
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b1;
    logic       fill_flags = 1'b1;
    logic [3:0] min_flags = '0;
    logic       crc32_sel = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_last = 1'b0;
    logic       in_abort = 1'b0;
    logic       in_ready;
    logic       tx_bit;

    int  nchecks = 0;
    int  nfail = 0;
    int  gap_mode = 0;
    int  phase = 0;
    int  ready_bad = 0;
    bit  cap_on = 0;
    int  ncap = 0;
    bit  cap [CAP_N];
    bit  expv [2][EXP_N];
    int  explen [2];
    int  st_ones;

    hdlc_tx u_dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fill_flags(fill_flags),
        .min_flags(min_flags), .crc32_sel(crc32_sel), .in_valid(in_valid),
        .in_data(in_data), .in_last(in_last), .in_abort(in_abort),
        .in_ready(in_ready), .tx_bit(tx_bit)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        #2;
        phase = phase + 1;
        bit_en = (gap_mode == 0) ? 1'b1 : ((phase % 3) == 0);
    end

    always @(posedge clk) begin
        if (cap_on && bit_en && rst_n) begin
            #1;
            if (ncap < CAP_N) cap[ncap] = tx_bit;
            ncap = ncap + 1;
        end
    end

    always @(negedge clk) if (rst_n && in_ready && !bit_en) ready_bad++;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        nchecks++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] gen(input int seed, input int i);
        return 8'(seed) ^ 8'(i * 29);
    endfunction

    function automatic logic [31:0] fcs_ref(input logic [31:0] c, input logic [7:0] d,
                                            input bit w32);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ (w32 ? 32'hEDB88320 : 32'h00008408);
            else r = r >> 1;
        end
        return r;
    endfunction

    task automatic push(input int k, input bit b);
        expv[k][explen[k]] = b;
        explen[k]++;
    endtask

    task automatic push_st(input int k, input bit b);
        push(k, b);
        st_ones = b ? st_ones + 1 : 0;
        if (st_ones == 5) begin
            push(k, 1'b0);
            st_ones = 0;
        end
    endtask

    task automatic push_flag(input int k);
        for (int j = 0; j < 8; j++) push(k, (j != 0) && (j != 7));
    endtask

    // ends: 0 = check sequence and closing flag, 1 = eight ones
    task automatic build(input int k, input int seed, input int len, input bit w32,
                         input int ends);
        logic [31:0] c;
        logic [7:0]  b;
        explen[k] = 0;
        st_ones = 0;
        c = w32 ? 32'hFFFFFFFF : 32'h0000FFFF;
        push_flag(k);
        for (int i = 0; i < len; i++) begin
            b = gen(seed, i);
            c = fcs_ref(c, b, w32);
            for (int j = 0; j < 8; j++) push_st(k, b[j]);
        end
        if (ends == 0) begin
            c = ~c;
            for (int j = 0; j < (w32 ? 32 : 16); j++) push_st(k, c[j]);
            push_flag(k);
        end else begin
            for (int j = 0; j < 8; j++) push(k, 1'b1);
        end
    endtask

    function automatic int find(input int k, input int from);
        bit hit;
        for (int p = (from < 0 ? 0 : from); p + explen[k] <= ncap; p++) begin
            hit = 1;
            for (int j = 0; j < explen[k]; j++)
                if (cap[p + j] != expv[k][j]) begin hit = 0; break; end
            if (hit) return p;
        end
        return -1;
    endfunction

    function automatic bit flag_at(input int p);
        if (p < 0 || p + 8 > ncap) return 0;
        for (int j = 0; j < 8; j++)
            if (cap[p + j] != ((j != 0) && (j != 7))) return 0;
        return 1;
    endfunction

    function automatic bit ones_at(input int p);
        if (p < 0 || p + 8 > ncap) return 0;
        for (int j = 0; j < 8; j++) if (!cap[p + j]) return 0;
        return 1;
    endfunction

    task automatic wait_acc();
        forever begin
            @(negedge clk);
            if (in_ready) begin
                @(posedge clk);
                #1;
                break;
            end
        end
    endtask

    // mode: 0 normal, 1 abort beat, 2 underrun
    task automatic send(input int seed, input int len, input int mode, input bit flip);
        for (int i = 0; i < len; i++) begin
            in_valid = 1'b1;
            in_data  = gen(seed, i);
            in_last  = (mode == 0) && (i == len - 1);
            in_abort = 1'b0;
            wait_acc();
            if (flip && i == 0) crc32_sel = ~crc32_sel;
        end
        if (mode == 1) begin
            in_data  = 8'h00;
            in_last  = 1'b0;
            in_abort = 1'b1;
            wait_acc();
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        in_abort = 1'b0;
    endtask

    task automatic start_run(input bit fill, input int minf, input bit w32, input int gm);
        @(negedge clk);
        rst_n      = 1'b0;
        cap_on     = 0;
        ncap       = 0;
        gap_mode   = gm;
        fill_flags = fill;
        min_flags  = 4'(minf);
        crc32_sel  = w32;
        in_valid   = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(tx_bit == 1'b1 && in_ready == 1'b0, "R1", "line state in reset",
            {tx_bit, in_ready}, 2);
        rst_n  = 1'b1;
        cap_on = 1;
    endtask

    task automatic finish_run(input int cycles);
        repeat (cycles) @(posedge clk);
        #3;
        cap_on = 0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=%0d expected=0", WATCHDOG);
        $display("  TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
        $finish;
    end

    initial begin
        int pa, pb, endb, zeros, pf;
        bit ok;

        // R1 and R2: flag fill with nothing offered
        start_run(1'b1, 0, 1'b0, 0);
        finish_run(120);
        chk(ones_at(0), "R1", "first byte after reset is ones", cap[0], 1);
        pf = -1;
        for (int p = 0; p < 24; p++) if (flag_at(p)) begin pf = p; break; end
        ok = (pf >= 0);
        for (int j = 0; j < 8; j++) ok = ok && flag_at(pf + 8 * j);
        chk(ok, "R2", "continuous flag fill", pf, 8);

        // R2: idle ones fill
        start_run(1'b0, 3, 1'b0, 0);
        finish_run(120);
        zeros = 0;
        for (int p = 0; p < ncap; p++) if (!cap[p]) zeros++;
        chk(zeros == 0, "R2", "idle ones fill zero count", zeros, 0);

        // Table: two frames back to back per entry
        for (int v = 0; v < NVEC; v++) begin
            int seed, la, lb, mf;
            bit w32, fill;
            seed = int'(VECS[v][31:24]);
            la   = int'(VECS[v][23:20]);
            lb   = int'(VECS[v][19:16]);
            mf   = int'(VECS[v][15:12]);
            w32  = VECS[v][8];
            fill = VECS[v][4];
            build(0, seed, la, w32, 0);
            build(1, seed ^ 8'h55, lb, w32, 0);
            start_run(fill, mf, w32, 0);
            send(seed, la, 0, 1'b0);
            send(seed ^ 8'h55, lb, 0, 1'b0);
            finish_run(300);
            pa = find(0, 0);
            chk(pa >= 0, "R6", $sformatf("vec %0d frame A image (R4 R5)", v), pa, 0);
            pb = find(1, pa + explen[0] - 8);
            chk(pb == pa + explen[0] - 8 + 8 * mf, "R7",
                $sformatf("vec %0d frame B position", v), pb, pa + explen[0] - 8 + 8 * mf);
            endb = pb + explen[1];
            chk(pb >= 0 && (fill ? flag_at(endb) : ones_at(endb)), "R2",
                $sformatf("vec %0d fill after frame B", v), fill, fill);
            if (!fill)
                chk(pa > 0 && cap[pa - 1] == 1'b1, "R11",
                    $sformatf("vec %0d opening flag after idle ones", v), pa, 8);
        end

        // R8: abort beat after ones-heavy data
        build(0, 8'h1F, 3, 1'b0, 1);
        start_run(1'b1, 0, 1'b0, 0);
        send(8'h1F, 3, 1, 1'b0);
        finish_run(120);
        pa = find(0, 0);
        chk(pa >= 0, "R8", "abort image", pa, 0);
        chk(flag_at(pa + explen[0]), "R8", "flag fill after abort", pa + explen[0], 0);

        // R9: underrun mid frame
        build(0, 8'hE7, 2, 1'b1, 1);
        start_run(1'b0, 0, 1'b1, 0);
        send(8'hE7, 2, 2, 1'b0);
        finish_run(120);
        pa = find(0, 0);
        chk(pa >= 0, "R9", "underrun abort image", pa, 0);
        chk(ones_at(pa + explen[0] + 8), "R9", "idle after underrun", pa, 0);

        // R6: width latched at frame start
        build(0, 8'h96, 4, 1'b1, 0);
        start_run(1'b1, 0, 1'b1, 0);
        send(8'h96, 4, 0, 1'b1);
        finish_run(150);
        chk(find(0, 0) >= 0, "R6", "32-bit check kept after select change", find(0, 0), 0);

        // R3 and R10: gapped bit slots
        ready_bad = 0;
        build(0, 8'hC3, 3, 1'b0, 0);
        start_run(1'b1, 2, 1'b0, 1);
        send(8'hC3, 3, 0, 1'b0);
        finish_run(600);
        chk(find(0, 0) >= 0, "R3", "frame image with gapped enable", find(0, 0), 0);
        chk(ready_bad == 0, "R10", "ready outside a bit slot", ready_bad, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
        $finish;
    end

endmodule